// File: doc/BRIEF.md
# Operating Mode Address Decoder

This block steers every CPU bus access to one of three targets: the on-chip program ROM, the on-chip RAM and register space, or the external memory bus. It also reports accesses that no target may take. It holds a single mode bit. This bit is taken from an external strap pin while reset is held, and it does not change until the next reset. The bit selects one of two configurations. In the first, the top of the address map is served by the on-chip ROM. In the second, there is no on-chip ROM, so that region goes to external memory.

A separate expansion-enable control bit is read live on every access. It decides how the gap between RAM and ROM is treated. When the bit is set, an access in the gap is a normal external cycle. When it is clear, an access in the gap selects no target. It then raises a registered, one-clock illegal-access pulse for the watchdog output.

The chip selects are combinational from the address and the access strobe. They are valid in the same cycle as the strobe. The illegal-access pulse appears in the cycle after the offending strobe.

Top module: `mode_addr_decoder`

## Requirements
- R1: The mode bit is loaded from `extStrap` on every clock edge while `rstN` is low. The value loaded at the last edge before release is kept, and changes of `extStrap` after release have no effect on decoding.
- R2: With the mode bit at 0 (internal ROM present), a strobed access to 0xC000..0xFFFF asserts `romSel` only.
- R3: A strobed access to 0x0000..0x02FF asserts `ramSel` only, in every mode and whatever the value of `expandEn`.
- R4: With the mode bit at 1 (no internal ROM), a strobed access to 0xC000..0xFFFF asserts `extSel` only.
- R5: With `expandEn` = 1, a strobed access to 0x0300..0xBFFF asserts `extSel` only and produces no illegal pulse.
- R6: With `expandEn` = 0, a strobed access to 0x0300..0xBFFF asserts no chip select. `illegalPulse` is then high in the following cycle.
- R7: `illegalPulse` is high for exactly one cycle per offending strobe cycle. Back-to-back offending strobes give back-to-back high cycles. A legal access, or a cycle without a strobe, gives no pulse.
- R8: At most one chip select is high at a time. All are low when `accStrobe` is low, whatever the address.
- R9: While `rstN` is low, `illegalPulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; also the mode-strap sampling window |
| extStrap | input | 1 | Mode strap: 1 = no internal ROM, 0 = internal ROM |
| expandEn | input | 1 | 1 = gap addresses go to external memory, 0 = gap addresses are illegal |
| accStrobe | input | 1 | High for each cycle that carries a bus access |
| addr | input | 16 | CPU address |
| romSel | output | 1 | Internal ROM select |
| ramSel | output | 1 | Internal RAM/register select |
| extSel | output | 1 | External memory select |
| illegalPulse | output | 1 | One-cycle illegal-access pulse, one cycle after the strobe |

## Verification
Accesses are issued at the exact region edges: 0x02FF against 0x0300, and 0xBFFF against 0xC000. These show whether the comparators are off by one. The same gap and ROM addresses are repeated with `expandEn` both clear and set, and under both strap values. This separates the live enable from the latched mode. The strap is flipped just after each reset release to show that it is not re-sampled. Back-to-back illegal strobes, and an idle cycle with an illegal address on the bus, show whether the pulse counts per strobe or merely follows the address.

// File: rtl/mode_dec_pkg.sv
package mode_dec_pkg;
  // Region hits produced by the address comparators.
  typedef struct packed {
    logic ramHit;
    logic romHit;
  } hitT;

  // Decision strobes produced by the mode controller.
  typedef struct packed {
    logic romSel;
    logic ramSel;
    logic extSel;
    logic fault;
  } selT;
endpackage

// File: rtl/addr_region_cmp.sv
module addr_region_cmp
  import mode_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h02FF,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000
) (
  input  logic [ADDR_W-1:0] addr,
  output hitT               hits
);
  // Two magnitude compares; the gap is whatever neither claims.
  always_comb begin
    hits.ramHit = (addr <= RAM_TOP);
    hits.romHit = (addr >= ROM_BASE);
  end
endmodule

// File: rtl/mode_select_ctrl.sv
module mode_select_ctrl
  import mode_dec_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic extStrap,
  input  logic expandEn,
  input  logic accStrobe,
  input  hitT  hits,
  output selT  sel,
  output logic illegalPulse
);
  logic extMode;

  // Strap is followed while reset is low and frozen once it is released.
  always_ff @(posedge clk) begin
    if (!rstN) extMode <= extStrap;
  end

  always_comb begin
    sel = '0;
    if (accStrobe) begin
      if (hits.ramHit)      sel.ramSel = 1'b1;
      else if (hits.romHit) begin
        if (extMode) sel.extSel = 1'b1;
        else         sel.romSel = 1'b1;
      end
      else if (expandEn)    sel.extSel = 1'b1;
      else                  sel.fault  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) illegalPulse <= 1'b0;
    else       illegalPulse <= sel.fault;
  end
endmodule

// File: rtl/mode_addr_decoder.sv
module mode_addr_decoder
  import mode_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h02FF,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extStrap,
  input  logic              expandEn,
  input  logic              accStrobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              romSel,
  output logic              ramSel,
  output logic              extSel,
  output logic              illegalPulse
);
  hitT hits;
  selT sel;

  addr_region_cmp #(
    .ADDR_W(ADDR_W), .RAM_TOP(RAM_TOP), .ROM_BASE(ROM_BASE)
  ) u_cmp (
    .addr(addr),
    .hits(hits)
  );

  mode_select_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .extStrap(extStrap),
    .expandEn(expandEn),
    .accStrobe(accStrobe),
    .hits(hits),
    .sel(sel),
    .illegalPulse(illegalPulse)
  );

  assign romSel = sel.romSel;
  assign ramSel = sel.ramSel;
  assign extSel = sel.extSel;
endmodule

// File: rtl/mode_addr_decoder_chk.sv
module mode_addr_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h02FF,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000
) (
  input logic              clk,
  input logic              rstN,
  input logic              expandEn,
  input logic              accStrobe,
  input logic [ADDR_W-1:0] addr,
  input logic              romSel,
  input logic              ramSel,
  input logic              extSel,
  input logic              illegalPulse
);
  logic anySel;
  assign anySel = romSel | ramSel | extSel;

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, ramSel, extSel}));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !accStrobe |-> !anySel);

  assert_ram_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && addr <= RAM_TOP) |-> ramSel);

  assert_rom_region_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && addr >= ROM_BASE) |-> (romSel || extSel));

  assert_expand_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && expandEn) |=> !illegalPulse);

  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && !anySel) |=> illegalPulse);

  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> $past(accStrobe && !anySel));
endmodule

bind mode_addr_decoder mode_addr_decoder_chk #(
  .ADDR_W(ADDR_W), .RAM_TOP(RAM_TOP), .ROM_BASE(ROM_BASE)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .expandEn(expandEn),
  .accStrobe(accStrobe),
  .addr(addr),
  .romSel(romSel),
  .ramSel(ramSel),
  .extSel(extSel),
  .illegalPulse(illegalPulse)
);

// File: tb/mode_addr_decoder_bench.sv
module mode_addr_decoder_bench;
  typedef struct {
    logic  rom, ram, ext, ill;
    string tag;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extStrap = 1'b0;
  logic expandEn = 1'b0;
  logic accStrobe = 1'b0;
  logic [15:0] addr = '0;
  logic romSel, ramSel, extSel, illegalPulse;

  int checks = 0;
  int errors = 0;
  logic benchMode = 1'b0;
  expT q[$];

  always #10 clk = ~clk;

  mode_addr_decoder u_mode_addr_decoder (
    .clk(clk), .rstN(rstN), .extStrap(extStrap), .expandEn(expandEn),
    .accStrobe(accStrobe), .addr(addr), .romSel(romSel), .ramSel(ramSel),
    .extSel(extSel), .illegalPulse(illegalPulse)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: one item per cycle, expectation computed from the requirements.
  task automatic issue(input logic [15:0] a, input logic en, input logic stb, input string tag);
    expT e;
    @(posedge clk); #2;
    addr = a; expandEn = en; accStrobe = stb;
    e.rom = 0; e.ram = 0; e.ext = 0; e.ill = 0; e.tag = tag;
    if (stb) begin
      if (a <= 16'h02FF)      e.ram = 1;
      else if (a >= 16'hC000) begin
        if (benchMode) e.ext = 1; else e.rom = 1;
      end
      else if (en)            e.ext = 1;
      else                    e.ill = 1;
    end
    q.push_back(e);
  endtask

  task automatic doReset(input logic strap);
    @(posedge clk); #2;
    rstN = 0; accStrobe = 0; extStrap = strap;
    @(posedge clk); @(posedge clk); #3;
    check("R9", "illegalPulse in reset", illegalPulse, 1'b0);
    @(posedge clk); #2;
    rstN = 1;
    extStrap = ~strap;  // R1: late strap change must be ignored
    benchMode = strap;
  endtask

  task automatic drain();
    issue(16'h0000, 0, 0, "R8");
    wait (q.size() == 0);
    @(posedge clk); @(posedge clk);
  endtask

  // Monitor: selects checked mid-cycle, the pulse one cycle later.
  initial begin
    logic pend = 0;
    expT last;
    forever begin
      @(negedge clk); #5;
      if (pend) begin
        check(last.tag, "illegalPulse", illegalPulse, last.ill);
        pend = 0;
      end
      if (q.size() > 0) begin
        last = q.pop_front();
        check(last.tag, "romSel", romSel, last.rom);
        check(last.tag, "ramSel", ramSel, last.ram);
        check(last.tag, "extSel", extSel, last.ext);
        pend = 1;
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    doReset(1'b0);
    issue(16'h0300, 0, 0, "R8");       // idle with gap address: nothing
    issue(16'h0000, 0, 1, "R3");
    issue(16'h02FF, 0, 1, "R3");
    issue(16'h0300, 0, 1, "R6");
    issue(16'hBFFF, 0, 1, "R7");       // back-to-back illegal
    issue(16'h0300, 0, 0, "R7");       // no strobe, no pulse
    issue(16'hC000, 0, 1, "R1");       // strap flipped after release: still internal
    issue(16'hFFFF, 0, 1, "R2");
    issue(16'h0300, 1, 1, "R5");
    issue(16'h8000, 1, 1, "R5");
    issue(16'hC000, 1, 1, "R2");
    issue(16'h02FF, 1, 1, "R3");
    drain();
    doReset(1'b1);
    issue(16'hC000, 0, 1, "R4");
    issue(16'hFFFF, 1, 1, "R4");
    issue(16'hC000, 0, 1, "R1");
    issue(16'h02FF, 0, 1, "R3");
    issue(16'h5000, 0, 1, "R6");
    issue(16'h5000, 1, 1, "R5");
    issue(16'hBFFF, 0, 1, "R6");
    issue(16'h0001, 0, 1, "R7");
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule